// File: doc/BRIEF.md
# Cartridge Real-Time Clock with Latched Readout

This block is the clock and bank-control portion of a cartridge controller on an 8-bit CPU bus. It keeps a running time of day: seconds, minutes, hours and a 9-bit day count. A 1 Hz tick pulse from outside advances that time. The CPU never reads the running counters directly. It reads a frozen copy, which is refreshed only when software issues a specific two-step write sequence. The copy stays constant while software reads its fields one at a time, so a carry that happens partway through cannot tear the result.

Writes are decoded on the top three address bits. One region enables or disables access to external RAM and to the clock. One region sets a 7-bit ROM bank. One region selects either a RAM bank or one of five clock registers. One region drives the snapshot handshake. Reads and writes in the external window (0xA000–0xBFFF) reach the selected clock register when access is on and the clock is selected. A write there loads the running counter. A read there returns the snapshot.

The 1 Hz source and battery backup sit outside this block.

Top module: `cart_rtc_mapper`

## Requirements
- R1: After a synchronous reset, the running time and the snapshot are all zero and the halt and overflow bits are clear. The ROM bank is 1, the RAM bank is 0 and access is disabled. The clock is deselected, `ram_en` is 0 and `rd_data` reads 0xFF.
- R2: A write to addresses 0x0000–0x1FFF with data 0x0A enables access, and data 0x00 disables it. Any other data leaves the access state unchanged.
- R3: A write to 0x2000–0x3FFF sets the ROM bank to data bits [6:0], with data bit 7 ignored. A resulting value of 0 is replaced by 1, so `rom_bank` is never 0.
- R4: A write to 0x4000–0x5FFF with data 0–3 sets the RAM bank to that value and deselects the clock. Data 0x08–0x0C selects clock register (data − 8). Any other data changes nothing. `ram_en` is high exactly when access is enabled and the clock is not selected.
- R5: Each clock cycle with `tick_1hz` high and halt clear advances the running time by one second. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into days.
- R6: The day count is 9 bits. Clock register 3 holds day bits [7:0] and register 4 bit 0 holds day bit 8. A carry out of day 511 returns the count to 0 and sets register 4 bit 7. That overflow bit stays set until a register-4 write clears it.
- R7: Register 4 bit 6 is a halt bit. While it is set, ticks do not change the running time.
- R8: A write to 0x6000–0x7FFF behaves as follows:
  - Data 0x01 while the latch flag is clear copies the running time into the snapshot and sets the flag.
  - Data 0x00 while the flag is set clears the flag.
  - Every other write there is ignored.
  - The snapshot changes at no other time.
- R9: A read address in 0xA000–0xBFFF, with access enabled and the clock selected, makes `rd_data` show the selected snapshot register on the next clock edge. All other addresses and states give 0xFF. The snapshot register layout is:
  - register 0 = seconds
  - register 1 = minutes
  - register 2 = hours
  - register 3 = day[7:0]
  - register 4 = {overflow, halt, 5'b0, day[8]}
- R10: A write in 0xA000–0xBFFF, with access enabled and the clock selected, loads the selected running field from the data using the R9 layout. Seconds and minutes take bits [5:0] and hours take bits [4:0]. Such a load takes precedence over a tick in the same cycle. Writes there with access disabled or with a RAM bank selected leave the clock unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second pulse, one clock wide per second |
| wr_en | input | 1 | CPU write strobe for the current address |
| addr | input | 16 | CPU address |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Registered read data for the external window |
| rom_bank | output | 7 | Selected switchable ROM bank, never 0 |
| ram_bank | output | 2 | Selected external RAM bank |
| ram_en | output | 1 | External RAM may respond in the window |

## Verification
The bench keeps a cycle-accurate model of the bus registers and time counters. It sweeps every data value through the bank and select regions, so an off-by-one in the 0x08–0x0C range or a missed zero-to-one bank substitution shows up as a wrong port value.

Counting is driven across every carry boundary, including the 511-to-0 day wrap. A design that cleared the overflow on its next tick, or that dropped day bit 8 into the wrong register, returns a different register-4 byte.

The latch handshake is exercised with repeated 1s, stray values and the 0-then-1 order. A snapshot that tracked the live counters, or that re-latched without the intervening 0, therefore reads back changed. Halt, write-versus-tick precedence and writes while disabled or while RAM is selected each have a visible effect on the next snapshot.

// File: rtl/cart_rtc_pkg.sv
package cart_rtc_pkg;

  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HR_W     = 5;
  localparam int DAY_W    = 9;
  localparam int NUM_REGS = 5;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int CLK_BASE = 8;

  // Address regions decoded from addr[15:13]
  localparam logic [2:0] RG_ENABLE  = 3'd0;
  localparam logic [2:0] RG_ROMBANK = 3'd1;
  localparam logic [2:0] RG_SELECT  = 3'd2;
  localparam logic [2:0] RG_LATCH   = 3'd3;
  localparam logic [2:0] RG_WINDOW  = 3'd5;

  typedef struct packed {
    logic             ovf;
    logic             halt;
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hrs;
    logic [MIN_W-1:0] mins;
    logic [SEC_W-1:0] secs;
  } rtc_time_t;

  // Byte view of one clock register as seen on the bus
  function automatic logic [7:0] reg_view(rtc_time_t t, logic [IDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      IDX_W'(0): b = 8'(t.secs);
      IDX_W'(1): b = 8'(t.mins);
      IDX_W'(2): b = 8'(t.hrs);
      IDX_W'(3): b = t.day[7:0];
      default:   b = {t.ovf, t.halt, 5'b0, t.day[DAY_W-1]};
    endcase
    return b;
  endfunction

endpackage

// File: rtl/rtc_run_counter.sv
module rtc_run_counter
  import cart_rtc_pkg::*;
#(
  parameter int SEC_MAX = 59,
  parameter int MIN_MAX = 59,
  parameter int HR_MAX  = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  output rtc_time_t        now
);

  rtc_time_t nxt;
  logic      sec_wrap, min_wrap, hr_wrap, day_wrap;

  always_comb begin
    sec_wrap = (now.secs == SEC_W'(SEC_MAX));
    min_wrap = (now.mins == MIN_W'(MIN_MAX));
    hr_wrap  = (now.hrs  == HR_W'(HR_MAX));
    day_wrap = &now.day;
    nxt = now;
    if (!sec_wrap) begin
      nxt.secs = now.secs + SEC_W'(1);
    end else begin
      nxt.secs = '0;
      if (!min_wrap) begin
        nxt.mins = now.mins + MIN_W'(1);
      end else begin
        nxt.mins = '0;
        if (!hr_wrap) begin
          nxt.hrs = now.hrs + HR_W'(1);
        end else begin
          nxt.hrs = '0;
          if (!day_wrap) begin
            nxt.day = now.day + DAY_W'(1);
          end else begin
            nxt.day = '0;
            nxt.ovf = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '0;
    end else if (ld_en) begin
      case (ld_idx)
        IDX_W'(0): now.secs <= ld_data[SEC_W-1:0];
        IDX_W'(1): now.mins <= ld_data[MIN_W-1:0];
        IDX_W'(2): now.hrs  <= ld_data[HR_W-1:0];
        IDX_W'(3): now.day[7:0] <= ld_data;
        IDX_W'(4): begin
          now.day[DAY_W-1] <= ld_data[0];
          now.halt         <= ld_data[6];
          now.ovf          <= ld_data[7];
        end
        default: ;
      endcase
    end else if (tick && !now.halt) begin
      now <= nxt;
    end
  end

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import cart_rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      latch_wr,
  input  logic [7:0] wr_data,
  input  rtc_time_t now,
  output rtc_time_t snap,
  output logic      armed
);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap  <= '0;
      armed <= 1'b0;
    end else if (latch_wr) begin
      if (!armed && wr_data == 8'h01) begin
        snap  <= now;
        armed <= 1'b1;
      end else if (armed && wr_data == 8'h00) begin
        armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cart_ctrl_regs.sv
module cart_ctrl_regs
  import cart_rtc_pkg::*;
#(
  parameter int ROM_W = 7,
  parameter int RAM_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       region,
  input  logic [7:0]       wr_data,
  output logic             acc_en,
  output logic [ROM_W-1:0] rom_bank,
  output logic [RAM_W-1:0] ram_bank,
  output logic             clk_sel,
  output logic [IDX_W-1:0] reg_idx
);

  localparam int RAM_BANKS = 1 << RAM_W;

  logic [ROM_W-1:0] rom_req;
  logic             is_ram_code, is_clk_code;

  always_comb begin
    rom_req     = wr_data[ROM_W-1:0];
    is_ram_code = (32'(wr_data) < RAM_BANKS);
    is_clk_code = (32'(wr_data) >= CLK_BASE) && (32'(wr_data) < CLK_BASE + NUM_REGS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_en   <= 1'b0;
      rom_bank <= ROM_W'(1);
      ram_bank <= '0;
      clk_sel  <= 1'b0;
      reg_idx  <= '0;
    end else if (wr_en) begin
      case (region)
        RG_ENABLE: begin
          if (wr_data == 8'h0A)      acc_en <= 1'b1;
          else if (wr_data == 8'h00) acc_en <= 1'b0;
        end
        RG_ROMBANK: rom_bank <= (rom_req == '0) ? ROM_W'(1) : rom_req;
        RG_SELECT: begin
          if (is_ram_code) begin
            ram_bank <= wr_data[RAM_W-1:0];
            clk_sel  <= 1'b0;
          end else if (is_clk_code) begin
            reg_idx <= IDX_W'(wr_data - 8'(CLK_BASE));
            clk_sel <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cart_rtc_mapper.sv
module cart_rtc_mapper
  import cart_rtc_pkg::*;
#(
  parameter int ROM_W = 7,
  parameter int RAM_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_1hz,
  input  logic             wr_en,
  input  logic [15:0]      addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic [ROM_W-1:0] rom_bank,
  output logic [RAM_W-1:0] ram_bank,
  output logic             ram_en
);

  logic [2:0]       region;
  logic             acc_en, clk_sel, latch_wr, win_wr, latch_armed;
  logic [IDX_W-1:0] reg_idx;
  rtc_time_t        now, snap;

  assign region   = addr[15:13];
  assign latch_wr = wr_en && (region == RG_LATCH);
  assign win_wr   = wr_en && (region == RG_WINDOW) && acc_en && clk_sel;
  assign ram_en   = acc_en && !clk_sel;

  cart_ctrl_regs #(.ROM_W(ROM_W), .RAM_W(RAM_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .region   (region),
    .wr_data  (wr_data),
    .acc_en   (acc_en),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .clk_sel  (clk_sel),
    .reg_idx  (reg_idx)
  );

  rtc_run_counter u_run (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_1hz),
    .ld_en   (win_wr),
    .ld_idx  (reg_idx),
    .ld_data (wr_data),
    .now     (now)
  );

  rtc_snapshot u_snap (
    .clk      (clk),
    .rst      (rst),
    .latch_wr (latch_wr),
    .wr_data  (wr_data),
    .now      (now),
    .snap     (snap),
    .armed    (latch_armed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'hFF;
    end else if (region == RG_WINDOW && acc_en && clk_sel) begin
      rd_data <= reg_view(snap, reg_idx);
    end else begin
      rd_data <= 8'hFF;
    end
  end

endmodule

// File: rtl/rtc_mapper_checker.sv
module rtc_mapper_checker
  import cart_rtc_pkg::*;
#(
  parameter int ROM_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_1hz,
  input logic             wr_en,
  input logic [15:0]      addr,
  input logic [7:0]       rd_data,
  input logic [ROM_W-1:0] rom_bank,
  input logic             acc_en,
  input rtc_time_t        now,
  input rtc_time_t        snap
);

  logic any_win_wr, any_latch_wr;
  assign any_win_wr   = wr_en && (addr[15:13] == RG_WINDOW);
  assign any_latch_wr = wr_en && (addr[15:13] == RG_LATCH);

  // R3: bank zero is never presented
  p_rom_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    rom_bank != '0);

  // R5: seconds wrap on a counted tick at 59
  p_sec_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (tick_1hz && !now.halt && now.secs == SEC_W'(59) && !any_win_wr) |=> (now.secs == '0));

  // R6: overflow flag is sticky without a window write
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (now.ovf && !any_win_wr) |=> now.ovf);

  // R7: halted time does not move
  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (now.halt && !any_win_wr) |=> $stable(now));

  // R8: snapshot only changes on a latch-region write
  p_snap_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !any_latch_wr |=> $stable(snap));

  // R9: disabled access reads as 0xFF
  p_rd_off_r9: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> (rd_data == 8'hFF));

endmodule

bind cart_rtc_mapper rtc_mapper_checker #(.ROM_W(ROM_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_1hz (tick_1hz),
  .wr_en    (wr_en),
  .addr     (addr),
  .rd_data  (rd_data),
  .rom_bank (rom_bank),
  .acc_en   (acc_en),
  .now      (now),
  .snap     (snap)
);

// File: tb/tb_cart_rtc_mapper.sv
module tb_cart_rtc_mapper;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;
  logic        ram_en;

  always #2 clk = ~clk;

  cart_rtc_mapper dut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rom_bank(rom_bank),
    .ram_bank(ram_bank), .ram_en(ram_en)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Reference state
  int m_sec = 0, m_min = 0, m_hr = 0, m_day = 0;
  bit m_halt = 0, m_ovf = 0;
  int s_sec = 0, s_min = 0, s_hr = 0, s_day = 0;
  bit s_halt = 0, s_ovf = 0;
  bit m_armed = 0, m_en = 0, m_csel = 0;
  int m_idx = 0, m_rom = 1, m_ram = 0;

  function automatic int reg_byte(int sec, int mn, int hr, int day, bit halt, bit ovf, int idx);
    case (idx)
      0: return sec;
      1: return mn;
      2: return hr;
      3: return day % 256;
      default: return (int'(ovf) << 7) | (int'(halt) << 6) | (day / 256);
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_tick();
    if (!m_halt) begin
      m_sec++;
      if (m_sec == 60) begin
        m_sec = 0; m_min++;
        if (m_min == 60) begin
          m_min = 0; m_hr++;
          if (m_hr == 24) begin
            m_hr = 0; m_day++;
            if (m_day == 512) begin m_day = 0; m_ovf = 1; end
          end
        end
      end
    end
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    case (a[15:13])
      3'd0: begin
        if (d == 8'h0A) m_en = 1;
        else if (d == 8'h00) m_en = 0;
      end
      3'd1: m_rom = (d[6:0] == 0) ? 1 : int'(d[6:0]);
      3'd2: begin
        if (d < 4) begin m_ram = d; m_csel = 0; end
        else if (d >= 8 && d <= 12) begin m_idx = d - 8; m_csel = 1; end
      end
      3'd3: begin
        if (!m_armed && d == 8'h01) begin
          s_sec = m_sec; s_min = m_min; s_hr = m_hr; s_day = m_day;
          s_halt = m_halt; s_ovf = m_ovf; m_armed = 1;
        end else if (m_armed && d == 8'h00) begin
          m_armed = 0;
        end
      end
      3'd5: begin
        if (m_en && m_csel) begin
          case (m_idx)
            0: m_sec = d & 63;
            1: m_min = d & 63;
            2: m_hr  = d & 31;
            3: m_day = (m_day & 256) | int'(d);
            default: begin
              m_day  = (m_day & 255) | (int'(d[0]) << 8);
              m_halt = d[6];
              m_ovf  = d[7];
            end
          endcase
        end
      end
      default: ;
    endcase
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      @(negedge clk);
      tick_1hz = 1'b1;
      repeat (n) begin
        @(negedge clk);
        model_tick();
      end
      tick_1hz = 1'b0;
    end
  endtask

  task automatic load(int idx, logic [7:0] v);
    wr(16'h4000, 8'(8 + idx));
    wr(16'hA000, v);
  endtask

  task automatic latch();
    wr(16'h6000, 8'h00);
    wr(16'h6000, 8'h01);
  endtask

  task automatic check_snap(string req);
    logic [7:0] v;
    for (int i = 0; i < 5; i++) begin
      wr(16'h4000, 8'(8 + i));
      rd(16'hA000 + 16'(i * 100), v);
      chk(req, v, reg_byte(s_sec, s_min, s_hr, s_day, s_halt, s_ovf, i));
    end
  endtask

  task automatic check_ports(string req);
    chk(req, rom_bank, m_rom);
    chk(req, ram_bank, m_ram);
    chk(req, ram_en, (m_en && !m_csel) ? 1 : 0);
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check_ports("R1");
    chk("R1", rd_data, 8'hFF);
    rd(16'hA000, v);
    chk("R1", v, 8'hFF);
    wr(16'h0000, 8'h0A);
    check_snap("R1");
    latch();
    check_snap("R1");

    // R2: access enable
    wr(16'h0000, 8'h00);
    wr(16'h4000, 8'h08);
    rd(16'hA000, v); chk("R2", v, 8'hFF);
    wr(16'h0000, 8'h05);
    rd(16'hA000, v); chk("R2", v, 8'hFF);
    wr(16'h1FFF, 8'h0A);
    rd(16'hA000, v); chk("R2", v, reg_byte(s_sec, s_min, s_hr, s_day, s_halt, s_ovf, 0));
    wr(16'h0000, 8'h0B);
    rd(16'hA000, v); chk("R2", v, reg_byte(s_sec, s_min, s_hr, s_day, s_halt, s_ovf, 0));

    // R3: ROM bank sweep
    for (int d = 0; d < 256; d++) begin
      wr(16'h2000 + 16'((d * 31) % 8192), 8'(d));
      chk("R3", rom_bank, m_rom);
    end

    // R4: select sweep
    for (int d = 0; d < 256; d++) begin
      wr(16'h4000 + 16'(d), 8'(d));
      check_ports("R4");
    end

    // R5: counting and carries
    for (int i = 0; i < 5; i++) load(i, 8'h00);
    ticks(1);    latch(); check_snap("R5");
    ticks(61);   latch(); check_snap("R5");
    ticks(3599); latch(); check_snap("R5");
    load(2, 8'd23); load(1, 8'd59); load(0, 8'd30);
    ticks(45);   latch(); check_snap("R5");

    // R6: 9-bit day count and sticky overflow
    load(0, 8'd59); load(1, 8'd59); load(2, 8'd23); load(3, 8'hFF); load(4, 8'h00);
    ticks(1); latch(); check_snap("R6");
    load(0, 8'd59); load(1, 8'd59); load(2, 8'd23); load(3, 8'hFF); load(4, 8'h01);
    ticks(1); latch(); check_snap("R6");
    chk("R6", s_ovf, 1);
    load(0, 8'd59); load(1, 8'd59); load(2, 8'd23);
    ticks(1); latch(); check_snap("R6");
    load(4, 8'h00);
    latch(); check_snap("R6");

    // R7: halt
    load(4, 8'h40);
    ticks(10); latch(); check_snap("R7");
    load(4, 8'h00);
    ticks(3); latch(); check_snap("R7");

    // R8: latch handshake
    latch();
    ticks(5);
    wr(16'h6000, 8'h01);
    check_snap("R8");
    wr(16'h6000, 8'h02);
    wr(16'h7FFF, 8'h00);
    wr(16'h6000, 8'h02);
    check_snap("R8");
    wr(16'h6000, 8'h01);
    check_snap("R8");
    chk("R8", s_sec, m_sec);

    // R9: read window decoding
    wr(16'h4000, 8'h00);
    rd(16'hA000, v); chk("R9", v, 8'hFF);
    rd(16'hBFFF, v); chk("R9", v, 8'hFF);
    wr(16'h4000, 8'h0A);
    rd(16'hBFFF, v); chk("R9", v, reg_byte(s_sec, s_min, s_hr, s_day, s_halt, s_ovf, 2));
    rd(16'h8000, v); chk("R9", v, 8'hFF);
    rd(16'hC000, v); chk("R9", v, 8'hFF);

    // R10: gated loads and load-over-tick precedence
    wr(16'h0000, 8'h00);
    load(0, 8'h11);
    wr(16'h0000, 8'h0A);
    latch(); check_snap("R10");
    wr(16'h4000, 8'h01);
    wr(16'hA000, 8'h22);
    latch(); check_snap("R10");
    wr(16'h4000, 8'h08);
    @(negedge clk);
    addr = 16'hA000; wr_data = 8'd5; wr_en = 1'b1; tick_1hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
    model_write(16'hA000, 8'd5);
    latch(); check_snap("R10");
    chk("R10", s_sec, 5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule